// File: doc/BRIEF.md
# Interrupt Entry and Return Sequencer

This block sits inside a processor core and runs the hardware side of taking an interrupt and returning from one. An arbiter outside the block presents a pending request with its vector and priority level. When the running instruction has finished and the level is above the current one, the sequencer raises acknowledge so the arbiter holds its outputs still. It then saves the program counter and the low byte of the status register on an internal stack. Last, it loads the new level into both the priority field and the context-select field of that byte, and it hands the vector to fetch.

The status low byte is laid out as `{ctx[3:0], ipl[3:0]}`. Bit 3 of the priority field marks trap levels (8 to 15), and user levels are 1 to 7. Because the level comparison is unsigned, any trap level outranks every user level. A return command pops the saved program counter and status byte, restores both and asks fetch to resume at that address. The stack has a fixed depth, so handlers can nest until the stack is full.

Top module: `intseq_top`

## Requirements
- R1: While reset is high and after it is released, `ack_o`, `busy_o`, `redirect_o`, `resume_o` and `ovf_o` are 0 and `sr_lo_o` is 0x00.
- R2: An entry starts only in an idle cycle where `irq_req_i` and `instr_done_i` are both 1 and `irq_lvl_i` is greater than `sr_lo_o[3:0]`. Otherwise the request causes no acknowledge and no change of status.
- R3: `ack_o` goes high the cycle after an entry is accepted and stays high for exactly two cycles. It falls in the same cycle that the new status value appears.
- R4: Two cycles after acceptance, `sr_lo_o` becomes `{lvl, lvl}` (context bits [7:4] and priority bits [3:0] both set to the accepted level). In that same cycle `redirect_o` pulses for one cycle with `vec_o` equal to the accepted vector.
- R5: Each entry pushes the program counter sampled at acceptance together with the status byte that was in force before the entry.
- R6: A return command in an idle cycle with a non-empty stack sets `resume_o` for one cycle, one cycle later. In that cycle `resume_pc_o` holds the saved program counter and `sr_lo_o` holds the restored status byte.
- R7: `busy_o` is high for the two cycles of an entry and for the one cycle of a return, and is low otherwise.
- R8: A request of a higher level nests on top of a running handler, and returns unwind the stack in last-in, first-out order.
- R9: A qualifying request that arrives while the stack holds DEPTH entries is not taken. `ack_o` stays low, the status is unchanged, and `ovf_o` rises and stays high until reset.
- R10: A return command with an empty stack is ignored: `busy_o` and `resume_o` stay low and the status is unchanged.
- R11: If a return command and a qualifying request arrive in the same idle cycle, the return is carried out and the request is not acknowledged.
- R12: A trap level (bit 3 set) is taken over any user level in force, and its value, with bit 3 set, lands in the priority field.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_req_i | input | 1 | Arbiter has a pending request |
| irq_lvl_i | input | LVL_W | Level of the pending request |
| irq_vec_i | input | VEC_W | Vector number of the pending request |
| instr_done_i | input | 1 | The current instruction completes this cycle |
| reti_i | input | 1 | Return-from-interrupt command |
| pc_i | input | PC_W | Current program counter |
| ack_o | output | 1 | Acknowledge; arbiter must hold its outputs |
| busy_o | output | 1 | Entry or return sequence in progress |
| redirect_o | output | 1 | One-cycle pulse: fetch from `vec_o` |
| vec_o | output | VEC_W | Vector of the interrupt being entered |
| resume_o | output | 1 | One-cycle pulse: fetch from `resume_pc_o` |
| resume_pc_o | output | PC_W | Program counter restored by a return |
| sr_lo_o | output | 2*LVL_W | Status low byte {context, priority} |
| ovf_o | output | 1 | Sticky stack overflow flag |

## Verification
An entry accepted at clock edge E shows `ack_o` and `busy_o` just after E. The new status, the vector and the redirect pulse appear just after E+2, and acknowledge and busy drop at that same edge. A return taken at edge R raises busy just after R and delivers `resume_o`, the restored PC and the restored status just after R+1. A rejected request, including one refused on overflow, is visible as an unchanged status and a set `ovf_o` just after E. The driver applies inputs one time unit after a rising edge, and every sample is taken at the falling edge that lies inside the cycle where the result is due. Expected vectors and status bytes go into a queue, in order, from a model stack kept by the driver. A monitor pops one entry from that queue for each redirect or resume pulse and compares it with the outputs.

// File: rtl/intseq_pkg.sv
package intseq_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_PUSH = 2'd1,
    ST_LOAD = 2'd2,
    ST_POP  = 2'd3
  } seq_state_t;
endpackage

// File: rtl/intseq_stack.sv
module intseq_stack #(
  parameter int DEPTH = 4,
  parameter int W     = 24
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         push,
  input  logic         pop,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] rdata,
  output logic         full,
  output logic         empty
);
  localparam int AW  = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int SPW = $clog2(DEPTH + 1);

  logic [W-1:0]   mem [DEPTH];
  logic [SPW-1:0] sp;
  logic [SPW-1:0] sp_dec;

  assign sp_dec = sp - 1'b1;
  assign full   = (sp == SPW'(DEPTH));
  assign empty  = (sp == '0);

  // memory: no reset, single write port, registered read
  always_ff @(posedge clk) begin
    if (push && !full) mem[sp[AW-1:0]] <= wdata;
    if (pop && !empty) rdata <= mem[sp_dec[AW-1:0]];
  end

  always_ff @(posedge clk) begin
    if (rst)                 sp <= '0;
    else if (push && !full)  sp <= sp + 1'b1;
    else if (pop && !empty)  sp <= sp_dec;
  end
endmodule

// File: rtl/intseq_ctrl.sv
module intseq_ctrl
  import intseq_pkg::*;
#(
  parameter int PC_W  = 16,
  parameter int VEC_W = 7,
  parameter int LVL_W = 4
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    irq_req_i,
  input  logic [LVL_W-1:0]        irq_lvl_i,
  input  logic [VEC_W-1:0]        irq_vec_i,
  input  logic                    instr_done_i,
  input  logic                    reti_i,
  input  logic [PC_W-1:0]         pc_i,
  input  logic                    stk_full,
  input  logic                    stk_empty,
  input  logic [PC_W+2*LVL_W-1:0] stk_rdata,
  output logic                    stk_push,
  output logic                    stk_pop,
  output logic [PC_W+2*LVL_W-1:0] stk_wdata,
  output logic                    ack_o,
  output logic                    busy_o,
  output logic                    redirect_o,
  output logic [VEC_W-1:0]        vec_o,
  output logic                    resume_o,
  output logic [PC_W-1:0]         resume_pc_o,
  output logic [2*LVL_W-1:0]      sr_lo_o,
  output logic                    ovf_o
);
  localparam int SRL_W = 2 * LVL_W;

  seq_state_t        state;
  logic [LVL_W-1:0]  lat_lvl;
  logic [VEC_W-1:0]  lat_vec;
  logic [PC_W-1:0]   lat_pc;
  logic              do_ret;
  logic              do_take;

  assign do_ret   = (state == ST_IDLE) && reti_i && !stk_empty;
  assign do_take  = (state == ST_IDLE) && !do_ret && irq_req_i && instr_done_i
                    && (irq_lvl_i > sr_lo_o[LVL_W-1:0]);
  assign stk_push  = (state == ST_PUSH);
  assign stk_pop   = do_ret;
  assign stk_wdata = {lat_pc, sr_lo_o};

  always_ff @(posedge clk) begin
    if (rst) begin
      state       <= ST_IDLE;
      ack_o       <= 1'b0;
      busy_o      <= 1'b0;
      redirect_o  <= 1'b0;
      resume_o    <= 1'b0;
      vec_o       <= '0;
      resume_pc_o <= '0;
      sr_lo_o     <= '0;
      ovf_o       <= 1'b0;
      lat_lvl     <= '0;
      lat_vec     <= '0;
      lat_pc      <= '0;
    end else begin
      redirect_o <= 1'b0;
      resume_o   <= 1'b0;
      unique case (state)
        ST_IDLE: begin
          if (do_ret) begin
            state  <= ST_POP;
            busy_o <= 1'b1;
          end else if (do_take) begin
            if (stk_full) begin
              ovf_o <= 1'b1;
            end else begin
              state   <= ST_PUSH;
              ack_o   <= 1'b1;
              busy_o  <= 1'b1;
              lat_lvl <= irq_lvl_i;
              lat_vec <= irq_vec_i;
              lat_pc  <= pc_i;
            end
          end
        end
        ST_PUSH: state <= ST_LOAD;
        ST_LOAD: begin
          sr_lo_o    <= {lat_lvl, lat_lvl};
          vec_o      <= lat_vec;
          redirect_o <= 1'b1;
          ack_o      <= 1'b0;
          busy_o     <= 1'b0;
          state      <= ST_IDLE;
        end
        ST_POP: begin
          sr_lo_o     <= stk_rdata[SRL_W-1:0];
          resume_pc_o <= stk_rdata[SRL_W +: PC_W];
          resume_o    <= 1'b1;
          busy_o      <= 1'b0;
          state       <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/intseq_top.sv
module intseq_top #(
  parameter int PC_W  = 16,
  parameter int VEC_W = 7,
  parameter int LVL_W = 4,
  parameter int DEPTH = 4
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               irq_req_i,
  input  logic [LVL_W-1:0]   irq_lvl_i,
  input  logic [VEC_W-1:0]   irq_vec_i,
  input  logic               instr_done_i,
  input  logic               reti_i,
  input  logic [PC_W-1:0]    pc_i,
  output logic               ack_o,
  output logic               busy_o,
  output logic               redirect_o,
  output logic [VEC_W-1:0]   vec_o,
  output logic               resume_o,
  output logic [PC_W-1:0]    resume_pc_o,
  output logic [2*LVL_W-1:0] sr_lo_o,
  output logic               ovf_o
);
  localparam int ENT_W = PC_W + 2 * LVL_W;

  logic             stk_push, stk_pop, stk_full, stk_empty;
  logic [ENT_W-1:0] stk_wdata, stk_rdata;

  intseq_ctrl #(.PC_W(PC_W), .VEC_W(VEC_W), .LVL_W(LVL_W)) u_ctrl (
    .clk(clk), .rst(rst),
    .irq_req_i(irq_req_i), .irq_lvl_i(irq_lvl_i), .irq_vec_i(irq_vec_i),
    .instr_done_i(instr_done_i), .reti_i(reti_i), .pc_i(pc_i),
    .stk_full(stk_full), .stk_empty(stk_empty), .stk_rdata(stk_rdata),
    .stk_push(stk_push), .stk_pop(stk_pop), .stk_wdata(stk_wdata),
    .ack_o(ack_o), .busy_o(busy_o), .redirect_o(redirect_o), .vec_o(vec_o),
    .resume_o(resume_o), .resume_pc_o(resume_pc_o), .sr_lo_o(sr_lo_o),
    .ovf_o(ovf_o)
  );

  intseq_stack #(.DEPTH(DEPTH), .W(ENT_W)) u_stack (
    .clk(clk), .rst(rst),
    .push(stk_push), .pop(stk_pop), .wdata(stk_wdata),
    .rdata(stk_rdata), .full(stk_full), .empty(stk_empty)
  );
endmodule

// File: rtl/intseq_chk.sv
module intseq_chk #(
  parameter int LVL_W = 4
) (
  input logic               clk,
  input logic               rst,
  input logic               irq_req_i,
  input logic               instr_done_i,
  input logic [LVL_W-1:0]   irq_lvl_i,
  input logic               ack_o,
  input logic               busy_o,
  input logic               redirect_o,
  input logic               resume_o,
  input logic [2*LVL_W-1:0] sr_lo_o,
  input logic               ovf_o
);
  AST_ENTRY_QUAL: assert property (@(posedge clk) disable iff (rst)
    $rose(ack_o) |-> $past(irq_req_i && instr_done_i && (irq_lvl_i > sr_lo_o[LVL_W-1:0]))); // R2
  AST_ACK_HOLD: assert property (@(posedge clk) disable iff (rst)
    $rose(ack_o) |=> ack_o); // R3
  AST_ACK_DROP_REDIR: assert property (@(posedge clk) disable iff (rst)
    $fell(ack_o) |-> redirect_o); // R3
  AST_REDIR_PULSE: assert property (@(posedge clk) disable iff (rst)
    redirect_o |=> !redirect_o); // R4
  AST_CTX_EQ_IPL: assert property (@(posedge clk) disable iff (rst)
    redirect_o |-> (sr_lo_o[2*LVL_W-1:LVL_W] == sr_lo_o[LVL_W-1:0])); // R4
  AST_RESUME_PULSE: assert property (@(posedge clk) disable iff (rst)
    resume_o |=> !resume_o); // R6
  AST_ACK_BUSY: assert property (@(posedge clk) disable iff (rst)
    ack_o |-> busy_o); // R7
  AST_OVF_STICKY: assert property (@(posedge clk) disable iff (rst)
    ovf_o |=> ovf_o); // R9
  AST_OVF_NOACK: assert property (@(posedge clk) disable iff (rst)
    $rose(ovf_o) |-> !ack_o); // R9
endmodule

bind intseq_top intseq_chk #(.LVL_W(LVL_W)) u_chk (
  .clk(clk), .rst(rst), .irq_req_i(irq_req_i), .instr_done_i(instr_done_i),
  .irq_lvl_i(irq_lvl_i), .ack_o(ack_o), .busy_o(busy_o),
  .redirect_o(redirect_o), .resume_o(resume_o), .sr_lo_o(sr_lo_o), .ovf_o(ovf_o)
);

// File: tb/intseq_top_tb_top.sv
module intseq_top_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        irq_req_i = 1'b0;
  logic [3:0]  irq_lvl_i = '0;
  logic [6:0]  irq_vec_i = '0;
  logic        instr_done_i = 1'b0;
  logic        reti_i = 1'b0;
  logic [15:0] pc_i = '0;
  logic        ack_o, busy_o, redirect_o, resume_o, ovf_o;
  logic [6:0]  vec_o;
  logic [15:0] resume_pc_o;
  logic [7:0]  sr_lo_o;

  typedef struct packed {
    logic        is_ret;
    logic [15:0] addr;
    logic [7:0]  sr;
  } exp_t;

  exp_t        expq[$];
  logic [23:0] mstk[$];
  logic [7:0]  msr = 8'h00;
  int          n_chk = 0;
  int          n_fail = 0;
  exp_t        it;

  always #5 clk = ~clk;

  intseq_top dut_i (
    .clk(clk), .rst(rst), .irq_req_i(irq_req_i), .irq_lvl_i(irq_lvl_i),
    .irq_vec_i(irq_vec_i), .instr_done_i(instr_done_i), .reti_i(reti_i),
    .pc_i(pc_i), .ack_o(ack_o), .busy_o(busy_o), .redirect_o(redirect_o),
    .vec_o(vec_o), .resume_o(resume_o), .resume_pc_o(resume_pc_o),
    .sr_lo_o(sr_lo_o), .ovf_o(ovf_o)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // monitor: one queued expectation per redirect or resume pulse
  always @(negedge clk) begin
    if (!rst && (redirect_o || resume_o)) begin
      if (expq.size() == 0) begin
        chk("R4/R6 unexpected pulse", 32'd1, 32'd0);
      end else begin
        it = expq.pop_front();
        if (redirect_o) begin
          chk("R4 pulse kind", 32'(it.is_ret), 32'd0);
          chk("R4 vector", 32'(vec_o), 32'(it.addr));
          chk("R4 status", 32'(sr_lo_o), 32'(it.sr));
        end else begin
          chk("R6 pulse kind", 32'(it.is_ret), 32'd1);
          chk("R6 resume pc (R5)", 32'(resume_pc_o), 32'(it.addr));
          chk("R6 status (R5)", 32'(sr_lo_o), 32'(it.sr));
        end
      end
    end
  end

  task automatic do_entry(input logic [3:0] lvl, input logic [6:0] vec,
                          input logic [15:0] pc, input logic done,
                          input bit take, input string tag);
    @(posedge clk); #1;
    irq_req_i = 1'b1; irq_lvl_i = lvl; irq_vec_i = vec; pc_i = pc; instr_done_i = done;
    @(posedge clk); #1;
    irq_req_i = 1'b0; instr_done_i = 1'b0;
    if (take) begin
      mstk.push_back({pc, msr});
      msr = {lvl, lvl};
      expq.push_back('{1'b0, 16'(vec), msr});
      @(negedge clk);
      chk({tag, " R3 ack first"}, 32'(ack_o), 32'd1);
      chk({tag, " R7 busy first"}, 32'(busy_o), 32'd1);
      @(negedge clk);
      chk({tag, " R3 ack second"}, 32'(ack_o), 32'd1);
      @(negedge clk);
      chk({tag, " R3 ack released"}, 32'(ack_o), 32'd0);
      chk({tag, " R7 busy released"}, 32'(busy_o), 32'd0);
    end else begin
      @(negedge clk);
      chk({tag, " no ack"}, 32'(ack_o), 32'd0);
      chk({tag, " not busy"}, 32'(busy_o), 32'd0);
      chk({tag, " status kept"}, 32'(sr_lo_o), 32'(msr));
    end
  endtask

  task automatic do_ret(input bit pop, input string tag);
    logic [23:0] e;
    @(posedge clk); #1;
    reti_i = 1'b1;
    @(posedge clk); #1;
    reti_i = 1'b0;
    if (pop) begin
      e = mstk.pop_back();
      msr = e[7:0];
      expq.push_back('{1'b1, e[23:8], e[7:0]});
      @(negedge clk);
      chk({tag, " R7 busy on return"}, 32'(busy_o), 32'd1);
      @(negedge clk);
      chk({tag, " R7 busy after return"}, 32'(busy_o), 32'd0);
    end else begin
      @(negedge clk);
      chk({tag, " busy stays low"}, 32'(busy_o), 32'd0);
      @(negedge clk);
      chk({tag, " no resume"}, 32'(resume_o), 32'd0);
      chk({tag, " status kept"}, 32'(sr_lo_o), 32'(msr));
    end
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired actual=running expected=done");
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;
    @(negedge clk);
    chk("R1 ack", 32'(ack_o), 32'd0);
    chk("R1 busy", 32'(busy_o), 32'd0);
    chk("R1 redirect", 32'(redirect_o), 32'd0);
    chk("R1 resume", 32'(resume_o), 32'd0);
    chk("R1 ovf", 32'(ovf_o), 32'd0);
    chk("R1 status", 32'(sr_lo_o), 32'd0);

    do_entry(4'd3, 7'd5, 16'h0100, 1'b0, 0, "R2 instr not done");
    do_entry(4'd0, 7'd5, 16'h0100, 1'b1, 0, "R2 level not above");
    do_entry(4'd3, 7'd5, 16'h0100, 1'b1, 1, "R4 entry lvl3");
    do_entry(4'd3, 7'd6, 16'h0110, 1'b1, 0, "R2 equal level masked");
    do_entry(4'd2, 7'd6, 16'h0110, 1'b1, 0, "R2 lower level masked");
    do_entry(4'd6, 7'd9, 16'h0200, 1'b1, 1, "R8 nest lvl6");
    do_entry(4'd9, 7'd2, 16'h0300, 1'b1, 1, "R12 trap lvl9");
    @(negedge clk);
    chk("R12 trap bit in priority field", 32'(sr_lo_o[3]), 32'd1);
    do_entry(4'd12, 7'd44, 16'h0400, 1'b1, 1, "R12 trap lvl12");
    do_entry(4'd14, 7'd45, 16'h0500, 1'b1, 0, "R9 overflow");
    chk("R9 ovf set", 32'(ovf_o), 32'd1);

    do_ret(1, "R8 unwind 1");
    do_ret(1, "R8 unwind 2");
    do_ret(1, "R8 unwind 3");
    do_ret(1, "R8 unwind 4");
    chk("R6 status back to zero", 32'(sr_lo_o), 32'd0);
    do_ret(0, "R10 empty return");

    do_entry(4'd5, 7'd11, 16'h0600, 1'b1, 1, "R4 entry lvl5");
    // return and qualifying request in the same idle cycle
    @(posedge clk); #1;
    irq_req_i = 1'b1; irq_lvl_i = 4'd7; irq_vec_i = 7'd12; pc_i = 16'h0700;
    instr_done_i = 1'b1; reti_i = 1'b1;
    @(posedge clk); #1;
    irq_req_i = 1'b0; instr_done_i = 1'b0; reti_i = 1'b0;
    begin
      logic [23:0] e;
      e = mstk.pop_back();
      msr = e[7:0];
      expq.push_back('{1'b1, e[23:8], e[7:0]});
    end
    @(negedge clk);
    chk("R11 no ack", 32'(ack_o), 32'd0);
    chk("R11 busy for return", 32'(busy_o), 32'd1);
    @(negedge clk);
    chk("R11 status restored", 32'(sr_lo_o), 32'd0);
    chk("R9 ovf still set", 32'(ovf_o), 32'd1);

    repeat (3) @(negedge clk);
    chk("R6 all pulses seen", 32'(expq.size()), 32'd0);
    finish_run();
  end
endmodule